// File: doc/BRIEF.md
# Galois LFSR Pseudo-Random Counter

This block is a left-shifting linear feedback shift register in the internal-XOR form. On each enabled clock the state word moves one place toward the most significant bit and a zero enters at bit 0. When the bit that falls off the top was one, a fixed tap mask is XORed into the shifted word. With the default width of 4 and the tap mask 0011 (generator x^4+x+1), the register visits all 15 non-zero patterns before it repeats. The all-zero pattern is never visited. This makes the block a counter whose order does not matter but whose clock rate must be high, or a cheap pseudo-random source.

A seed can be written through a load strobe. A zero seed is replaced by 0001 so the register cannot lock up. The block keeps the seed from the most recent load or reset. It raises a one-cycle flag when stepping brings the state back to that seed, which marks a complete period. The control pins and the parallel state output are plain level signals: the state is always valid, and there is no handshake or back-pressure.

Top module: `lfsr_walker`

## Requirements
- R1: While reset is high at a clock edge, the state becomes 0001, the stored seed becomes 0001 and period_done becomes 0.
- R2: On an enabled step, the new state is the old state shifted left by one with a zero entering bit 0. If the old bit 3 (the MSB) was 1, the shifted word is also XORed with the tap mask 0011.
- R3: Starting at 0001, successive steps visit 0010, 0100, 1000, 0011, 0110, 1100, 1011, 0101, 1010, 0111, 1110, 1111, 1101, 1001, and the next step returns to 0001.
- R4: Any 15 consecutive steps from any non-zero state visit 15 distinct non-zero states, and the state after them equals the starting state.
- R5: With step_en low and seed_load low, the state, the stored seed and the output all hold.
- R6: When seed_load is high at a clock edge, the state and the stored seed take seed_value, whether or not step_en is high. period_done is 0 after that edge.
- R7: A seed_value of 0000 is loaded as 0001.
- R8: period_done is 1 for exactly one cycle after a step whose result equals the stored seed, and it is 0 in every other cycle.
- R9: The state is never 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the register by one step |
| seed_load | input | 1 | Load seed_value; takes priority over step_en |
| seed_value | input | WIDTH | Seed to load; zero is replaced by 0001 |
| state_q | output | WIDTH | Current register state |
| period_done | output | 1 | One-cycle pulse when a step returns the state to the stored seed |

## Verification
On every cycle, the assertions check the shift-and-XOR step rule, the hold when no step is enabled, load priority with zero substitution, the absence of the all-zero state, and that period_done lasts one cycle and only while the state equals the stored seed. Only the bench scenarios can show the exact 15-state order, that no state repeats within a period, and that the wrap flag appears after exactly 15 steps from seeds other than 0001. Random mixes of loads, steps and holds are compared cycle by cycle against a model in the bench.

// File: rtl/lfsr_walker_pkg.sv
package lfsr_walker_pkg;
  localparam int unsigned DEF_WIDTH = 4;
  localparam logic [DEF_WIDTH-1:0] DEF_TAPS  = 4'b0011;
  localparam logic [DEF_WIDTH-1:0] DEF_RESET = 4'b0001;
endpackage

// File: rtl/lfsr_next_step.sv
module lfsr_next_step #(
  parameter int unsigned WIDTH = lfsr_walker_pkg::DEF_WIDTH,
  parameter logic [WIDTH-1:0] TAPS = lfsr_walker_pkg::DEF_TAPS
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);
  localparam int unsigned TOP = WIDTH - 1;
  logic fb;
  assign fb = cur[TOP];

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_low
      if (TAPS[i]) begin : g_tap
        assign nxt[i] = fb;
      end else begin : g_notap
        assign nxt[i] = 1'b0;
      end
    end else begin : g_up
      if (TAPS[i]) begin : g_tap
        assign nxt[i] = cur[i-1] ^ fb;
      end else begin : g_notap
        assign nxt[i] = cur[i-1];
      end
    end
  end
endmodule

// File: rtl/lfsr_seed_guard.sv
module lfsr_seed_guard #(
  parameter int unsigned WIDTH = lfsr_walker_pkg::DEF_WIDTH
) (
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] safe
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};
  always_comb begin
    safe = raw;
    if (raw == '0) safe = ONE;
  end
endmodule

// File: rtl/lfsr_wrap_detect.sv
module lfsr_wrap_detect #(
  parameter int unsigned WIDTH = lfsr_walker_pkg::DEF_WIDTH,
  parameter logic [WIDTH-1:0] RESET_SEED = lfsr_walker_pkg::DEF_RESET
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_fire,
  input  logic [WIDTH-1:0] load_val,
  input  logic             step_fire,
  input  logic [WIDTH-1:0] step_val,
  input  logic [WIDTH-1:0] state_now,
  output logic             wrap_pulse
);
  logic [WIDTH-1:0] seed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seed_q     <= RESET_SEED;
      wrap_pulse <= 1'b0;
    end else if (load_fire) begin
      seed_q     <= load_val;
      wrap_pulse <= 1'b0;
    end else if (step_fire) begin
      wrap_pulse <= (step_val == seed_q);
    end else begin
      wrap_pulse <= 1'b0;
    end
  end

  p_wrap_match_r8: assert property (@(posedge clk) disable iff (rst)
    wrap_pulse |-> (state_now == seed_q));
  p_wrap_single_r8: assert property (@(posedge clk) disable iff (rst)
    wrap_pulse |=> !wrap_pulse);
endmodule

// File: rtl/lfsr_walker.sv
module lfsr_walker #(
  parameter int unsigned WIDTH = lfsr_walker_pkg::DEF_WIDTH,
  parameter logic [WIDTH-1:0] TAPS = lfsr_walker_pkg::DEF_TAPS,
  parameter logic [WIDTH-1:0] RESET_STATE = lfsr_walker_pkg::DEF_RESET
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             seed_load,
  input  logic [WIDTH-1:0] seed_value,
  output logic [WIDTH-1:0] state_q,
  output logic             period_done
);
  localparam int unsigned TOP = WIDTH - 1;
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] RST_SAFE = (RESET_STATE == '0) ? ONE : RESET_STATE;

  logic [WIDTH-1:0] step_val;
  logic [WIDTH-1:0] seed_safe;
  logic             was_live;

  lfsr_next_step #(.WIDTH(WIDTH), .TAPS(TAPS)) u_step (
    .cur (state_q),
    .nxt (step_val)
  );

  lfsr_seed_guard #(.WIDTH(WIDTH)) u_guard (
    .raw  (seed_value),
    .safe (seed_safe)
  );

  lfsr_wrap_detect #(.WIDTH(WIDTH), .RESET_SEED(RST_SAFE)) u_wrap (
    .clk        (clk),
    .rst        (rst),
    .load_fire  (seed_load),
    .load_val   (seed_safe),
    .step_fire  (step_en),
    .step_val   (step_val),
    .state_now  (state_q),
    .wrap_pulse (period_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RST_SAFE;
    end else if (seed_load) begin
      state_q <= seed_safe;
    end else if (step_en) begin
      state_q <= step_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) was_live <= 1'b0;
    else     was_live <= 1'b1;
  end

  p_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
    was_live |-> (state_q != '0));
  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    (was_live && $past(seed_load) && ($past(seed_value) != '0))
      |-> (state_q == $past(seed_value)));
  p_zero_seed_r7: assert property (@(posedge clk) disable iff (rst)
    (was_live && $past(seed_load) && ($past(seed_value) == '0))
      |-> (state_q == ONE));
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (was_live && !$past(seed_load) && !$past(step_en))
      |-> ($stable(state_q) && !period_done));
  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (was_live && !$past(seed_load) && $past(step_en) && !$past(state_q[TOP]))
      |-> (state_q == ($past(state_q) << 1)));
  p_shift_tap_r2: assert property (@(posedge clk) disable iff (rst)
    (was_live && !$past(seed_load) && $past(step_en) && $past(state_q[TOP]))
      |-> (state_q == (($past(state_q) << 1) ^ TAPS)));
endmodule

// File: tb/lfsr_walker_test.sv
module lfsr_walker_test;
  localparam int W = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_en = 1'b0;
  logic seed_load = 1'b0;
  logic [W-1:0] seed_value = '0;
  logic [W-1:0] state_q;
  logic period_done;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_state;
  logic [W-1:0] m_seed;
  logic         m_wrap;

  always #2 clk = ~clk;

  lfsr_walker uut (
    .clk(clk), .rst(rst), .step_en(step_en), .seed_load(seed_load),
    .seed_value(seed_value), .state_q(state_q), .period_done(period_done)
  );

  function automatic logic [W-1:0] f_step(input logic [W-1:0] s);
    logic [W-1:0] r;
    r = {s[W-2:0], 1'b0};
    if (s[W-1]) r = r ^ 4'b0011;
    return r;
  endfunction

  function automatic logic [W-1:0] f_order(input int k);
    case (k)
      0: return 4'b0001;  1: return 4'b0010;  2: return 4'b0100;
      3: return 4'b1000;  4: return 4'b0011;  5: return 4'b0110;
      6: return 4'b1100;  7: return 4'b1011;  8: return 4'b0101;
      9: return 4'b1010; 10: return 4'b0111; 11: return 4'b1110;
     12: return 4'b1111; 13: return 4'b1101; default: return 4'b1001;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, update model, check at following negedge
  task automatic cyc(input bit r, input bit en, input bit ld, input logic [W-1:0] sv);
    rst = r; step_en = en; seed_load = ld; seed_value = sv;
    if (r) begin
      m_state = 4'b0001; m_seed = 4'b0001; m_wrap = 1'b0;
    end else if (ld) begin
      m_state = (sv == 0) ? 4'b0001 : sv; m_seed = m_state; m_wrap = 1'b0;
    end else if (en) begin
      m_state = f_step(m_state); m_wrap = (m_state == m_seed);
    end else begin
      m_wrap = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic cmp(input string req);
    chk(state_q === m_state, req, int'(state_q), int'(m_state));
    chk(period_done === m_wrap, {req, " period_done"}, int'(period_done), int'(m_wrap));
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] seen;
    void'($urandom(32'd4242));
    @(negedge clk);
    cyc(1, 0, 0, 0);
    cyc(1, 1, 1, 4'b0110);
    cmp("R1 reset");
    rst = 0;
    // R3 exact order and R8 wrap after 15 steps
    for (int k = 1; k <= 15; k++) begin
      cyc(0, 1, 0, 0);
      chk(state_q === f_order(k % 15), "R3 order", int'(state_q), int'(f_order(k % 15)));
      chk(period_done === (k == 15), "R8 wrap", int'(period_done), int'(k == 15));
    end
    cyc(0, 0, 0, 0);
    cmp("R8 pulse drops");
    // R5 hold
    for (int k = 0; k < 4; k++) begin
      cyc(0, 0, 0, $urandom);
      cmp("R5 hold");
    end
    // R6 load priority over step
    cyc(0, 1, 1, 4'b1011);
    cmp("R6 load with step");
    // R7 zero seed
    cyc(0, 1, 1, 4'b0000);
    cmp("R7 zero seed");
    // R4 distinct period from every seed
    for (int s = 1; s < 16; s++) begin
      cyc(0, 0, 1, s[W-1:0]);
      seen = '0;
      for (int k = 0; k < 15; k++) begin
        cyc(0, 1, 0, 0);
        chk(!seen[state_q] && state_q != 0, "R4 distinct", int'(state_q), int'(f_step(state_q)));
        seen[state_q] = 1'b1;
        cmp("R2 step");
      end
      chk(state_q === s[W-1:0], "R4 back to seed", int'(state_q), s);
      chk(period_done === 1'b1, "R8 wrap seed", int'(period_done), 1);
    end
    // random mix
    for (int k = 0; k < 3000; k++) begin
      automatic int pick = $urandom_range(0, 99);
      cyc(pick < 1, pick < 80, (pick >= 90), $urandom_range(0, 15));
      cmp("R2/R6/R8 random");
      chk(state_q != 0, "R9 nonzero", int'(state_q), 1);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule